// File: doc/BRIEF.md
# Packet-Atomic Readback FIFO

This block buffers readback data that reaches it in packets of four 32-bit words. A bus master drains the buffer one word at a time. A packet is stored only when there is room for all four of its words, and then all four are stored in the same clock cycle. When there is less room than that, the whole packet is discarded. A sticky flag records that the discard happened, and it stays set until reset.

The storage holds 2048 words. It is split into four banks, one for each word position in a packet, so one write port per bank is enough to store a packet in a single cycle. On the read side a strobe removes the oldest word and returns it on the following cycle. A strobe while the buffer is empty returns zero and leaves every piece of state unchanged. The current fill level and an empty indication are outputs, so a master can see how much data is ready before it reads.

Top module: `pkt_readback_fifo`

## Requirements
- R1: After reset, `occupancy` is 0, `empty` is 1, `drop_seen` is 0 and `rd_data` is 0.
- R2: A packet offered with `pkt_valid` high while `occupancy` is at most DEPTH-4 is stored in full. On the next cycle `occupancy` is 4 higher, less 1 if a pop happened in the same cycle.
- R3: Words leave in arrival order. Within one packet, word 0 is `pkt_data[31:0]` and leaves first, followed by word 1 `[63:32]`, word 2 `[95:64]` and word 3 `[127:96]`.
- R4: When `rd_en` is high in cycle N and the FIFO is not empty, the oldest word appears on `rd_data` in cycle N+1. In every other cycle `rd_data` is 0.
- R5: A packet offered while `occupancy` is above DEPTH-4 is discarded whole. `occupancy` does not change, and none of the packet's words is ever read out.
- R6: The first discarded packet sets `drop_seen`. The flag then stays at 1 until reset, whatever reads or packets follow.
- R7: A `rd_en` pulse while `empty` is 1 returns 0 on `rd_data` on the next cycle and leaves `occupancy` at 0.
- R8: When a packet is accepted and a word is popped in the same cycle, the acceptance test uses the occupancy from before the pop. The popped word is the old head, and `occupancy` rises by exactly 3.
- R9: The FIFO holds exactly DEPTH (2048) words. A packet that arrives at 2044 is accepted and brings the level to 2048. A packet that arrives at 2045 to 2048 is dropped. `occupancy` never exceeds DEPTH.
- R10: `empty` is 1 exactly when `occupancy` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Packet present on `pkt_data` this cycle |
| pkt_data | input | 128 | Four words; word 0 in bits [31:0] |
| rd_en | input | 1 | Bus read strobe; pops one word if not empty |
| rd_data | output | 32 | Popped word, one cycle after `rd_en`; 0 otherwise |
| occupancy | output | 12 | Number of stored words, 0 to 2048 |
| empty | output | 1 | No words stored |
| drop_seen | output | 1 | Sticky: a packet was discarded since reset |

## Verification
A corrupted fill count shows up on `occupancy` at the next sample. A count that is too high or too low also shifts the boundary between accepting and dropping packets. The bench therefore fills the buffer exactly to 2048, then probes 2047 and 2044 with further packets, and compares `occupancy` and `drop_seen` after each one. A wrong read pointer or bank select shows up as a miscompare on the very next `rd_data` word. Every word read is compared against a queue model, so a single misplaced word is reported at the read where it surfaces rather than at the end of the run.

// File: rtl/pkt_fifo_pkg.sv
package pkt_fifo_pkg;
   localparam int unsigned WORD_W     = 32;
   localparam int unsigned PKT_WORDS  = 4;
   localparam int unsigned FIFO_DEPTH = 2048;
endpackage

// File: rtl/rbf_bank.sv
module rbf_bank #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ROWS   = 512,
   localparam int unsigned ROW_W = $clog2(ROWS)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ROW_W-1:0]  wr_row,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [ROW_W-1:0]  rd_row,
   output logic [DATA_W-1:0] rd_q
);
   logic [DATA_W-1:0] mem [ROWS];

   // one write and one synchronous read port per bank
   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_row] <= wr_data;
      if (rd_en) rd_q <= mem[rd_row];
   end
endmodule

// File: rtl/rbf_ctrl.sv
module rbf_ctrl #(
   parameter int unsigned DEPTH     = 2048,
   parameter int unsigned PKT_WORDS = 4,
   localparam int unsigned OCC_W = $clog2(DEPTH + 1),
   localparam int unsigned PTR_W = $clog2(DEPTH),
   localparam int unsigned ROW_W = PTR_W - $clog2(PKT_WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pkt_valid,
   input  logic             rd_en,
   output logic             push,
   output logic             pop,
   output logic [ROW_W-1:0] wr_row,
   output logic [PTR_W-1:0] rd_ptr,
   output logic [OCC_W-1:0] count,
   output logic             is_empty,
   output logic             drop_flag
);
   localparam logic [OCC_W-1:0] ACCEPT_LIM = OCC_W'(DEPTH - PKT_WORDS);
   localparam logic [OCC_W-1:0] PKT_INC    = OCC_W'(PKT_WORDS);

   logic room_ok;
   logic [OCC_W-1:0] count_nxt;

   // acceptance is judged on the level before any pop of the same cycle
   assign room_ok  = (count <= ACCEPT_LIM);
   assign push     = pkt_valid && room_ok;
   assign is_empty = (count == '0);
   assign pop      = rd_en && !is_empty;

   always_comb begin
      count_nxt = count;
      if (push) count_nxt = count_nxt + PKT_INC;
      if (pop)  count_nxt = count_nxt - OCC_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count     <= '0;
         wr_row    <= '0;
         rd_ptr    <= '0;
         drop_flag <= 1'b0;
      end else begin
         count <= count_nxt;
         if (push) wr_row <= wr_row + ROW_W'(1);
         if (pop)  rd_ptr <= rd_ptr + PTR_W'(1);
         if (pkt_valid && !room_ok) drop_flag <= 1'b1;
      end
   end
endmodule

// File: rtl/pkt_readback_fifo.sv
module pkt_readback_fifo
   import pkt_fifo_pkg::*;
#(
   parameter int unsigned DATA_W    = WORD_W,
   parameter int unsigned DEPTH     = FIFO_DEPTH,
   parameter int unsigned PKT_WORDS = pkt_fifo_pkg::PKT_WORDS,
   localparam int unsigned OCC_W = $clog2(DEPTH + 1),
   localparam int unsigned PKT_W = DATA_W * PKT_WORDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pkt_valid,
   input  logic [PKT_W-1:0]  pkt_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic [OCC_W-1:0]  occupancy,
   output logic              empty,
   output logic              drop_seen
);
   localparam int unsigned PTR_W = $clog2(DEPTH);
   localparam int unsigned SEL_W = $clog2(PKT_WORDS);
   localparam int unsigned ROW_W = PTR_W - SEL_W;
   localparam int unsigned ROWS  = DEPTH / PKT_WORDS;

   // elaboration-time parameter checks
   if (PKT_WORDS < 2 || (PKT_WORDS & (PKT_WORDS - 1)) != 0) begin : g_bad_pkt
      $error("PKT_WORDS must be a power of two, at least 2");
   end
   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2 * PKT_WORDS) begin : g_bad_depth
      $error("DEPTH must be a power of two holding at least two packets");
   end
   if (DATA_W == 0) begin : g_bad_width
      $error("DATA_W must be non-zero");
   end

   logic             push, pop;
   logic [ROW_W-1:0] wr_row;
   logic [PTR_W-1:0] rd_ptr;
   logic [SEL_W-1:0] sel_q;
   logic             pop_q;
   logic [DATA_W-1:0] bank_q [PKT_WORDS];

   rbf_ctrl #(.DEPTH(DEPTH), .PKT_WORDS(PKT_WORDS)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .pkt_valid (pkt_valid),
      .rd_en     (rd_en),
      .push      (push),
      .pop       (pop),
      .wr_row    (wr_row),
      .rd_ptr    (rd_ptr),
      .count     (occupancy),
      .is_empty  (empty),
      .drop_flag (drop_seen)
   );

   // one bank per word position: a whole packet lands in one row
   for (genvar b = 0; b < PKT_WORDS; b++) begin : g_bank
      rbf_bank #(.DATA_W(DATA_W), .ROWS(ROWS)) u_bank (
         .clk     (clk),
         .wr_en   (push),
         .wr_row  (wr_row),
         .wr_data (pkt_data[b*DATA_W +: DATA_W]),
         .rd_en   (pop && (rd_ptr[SEL_W-1:0] == SEL_W'(b))),
         .rd_row  (rd_ptr[PTR_W-1:SEL_W]),
         .rd_q    (bank_q[b])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pop_q <= 1'b0;
         sel_q <= '0;
      end else begin
         pop_q <= pop;
         sel_q <= rd_ptr[SEL_W-1:0];
      end
   end

   assign rd_data = pop_q ? bank_q[sel_q] : '0;
endmodule

// File: rtl/rbf_checker.sv
module rbf_checker #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned DEPTH     = 2048,
   parameter int unsigned PKT_WORDS = 4,
   localparam int unsigned OCC_W = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pkt_valid,
   input logic              rd_en,
   input logic [DATA_W-1:0] rd_data,
   input logic [OCC_W-1:0]  occupancy,
   input logic              empty,
   input logic              drop_seen
);
   localparam logic [OCC_W-1:0] LIM = OCC_W'(DEPTH - PKT_WORDS);
   localparam logic [OCC_W-1:0] CAP = OCC_W'(DEPTH);
   localparam logic [OCC_W-1:0] INC = OCC_W'(PKT_WORDS);

   AST_ACCEPT_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && occupancy <= LIM && !rd_en) |=> (occupancy == $past(occupancy) + INC)); // R2
   AST_NO_RD_DATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> (rd_data == '0)); // R4
   AST_DROP_HOLDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && occupancy > LIM && !rd_en) |=> ($stable(occupancy) && drop_seen)); // R5
   AST_DROP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      drop_seen |=> drop_seen); // R6
   AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && empty && !pkt_valid) |=> (rd_data == '0 && occupancy == '0)); // R7
   AST_PUSH_POP_NET: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && rd_en && !empty && occupancy <= LIM) |=> (occupancy == $past(occupancy) + INC - OCC_W'(1))); // R8
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      occupancy <= CAP); // R9
   AST_EMPTY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      empty == (occupancy == '0)); // R10
endmodule

bind pkt_readback_fifo rbf_checker #(
   .DATA_W(DATA_W), .DEPTH(DEPTH), .PKT_WORDS(PKT_WORDS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .rd_en(rd_en),
   .rd_data(rd_data), .occupancy(occupancy), .empty(empty), .drop_seen(drop_seen)
);

// File: tb/pkt_readback_fifo_tb.sv
module pkt_readback_fifo_tb;
   localparam int DEPTH = 2048;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         pkt_valid = 1'b0;
   logic [127:0] pkt_data = '0;
   logic         rd_en = 1'b0;
   logic [31:0]  rd_data;
   logic [11:0]  occupancy;
   logic         empty;
   logic         drop_seen;

   int vectors = 0;
   int miscompares = 0;
   int mcount = 0;
   logic [31:0] model[$];
   logic [31:0] pend[$];
   logic sample_now = 1'b0;
   logic [15:0] pkt_id = '0;

   always #4 clk = ~clk;

   pkt_readback_fifo u_dut (
      .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
      .rd_en(rd_en), .rd_data(rd_data), .occupancy(occupancy),
      .empty(empty), .drop_seen(drop_seen)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
   endtask

   // monitor: compare read data one cycle after the strobe
   always @(posedge clk) sample_now <= rd_en;
   always @(negedge clk) begin
      if (sample_now) begin
         logic [31:0] e;
         e = pend.size() ? pend.pop_front() : 32'h0;
         chk("R3 R4 R7 read word", rd_data, e);
      end
   end

   // driver: optional packet and optional read in one cycle
   task automatic cycle(input bit do_pkt, input bit do_rd);
      @(negedge clk);
      if (do_rd) pend.push_back(model.size() ? model.pop_front() : 32'h0);
      if (do_pkt) begin
         pkt_id++;
         for (int w = 0; w < 4; w++) pkt_data[w*32 +: 32] = {pkt_id, 12'hA50, 4'(w)};
         if (mcount <= DEPTH - 4) begin
            for (int w = 0; w < 4; w++) model.push_back(pkt_data[w*32 +: 32]);
            mcount += 4;
         end
      end
      if (do_rd && mcount > 0 && !(do_pkt && model.size() == mcount && mcount == 4 && pend[$] == 32'h0))
         mcount -= 1;
      pkt_valid = do_pkt;
      rd_en = do_rd;
      @(negedge clk);
      pkt_valid = 1'b0;
      rd_en = 1'b0;
   endtask

   task automatic chk_level(string req);
      chk({req, " occupancy"}, 32'(occupancy), 32'(mcount));
      chk({req, " empty"}, 32'(empty), 32'(mcount == 0));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 occupancy", 32'(occupancy), 0);
      chk("R1 empty", 32'(empty), 1);
      chk("R1 drop_seen", 32'(drop_seen), 0);
      chk("R1 rd_data", rd_data, 0);

      // R7 read while empty
      cycle(0, 1);
      chk_level("R7");

      // R2 R3 several packets, partial drain
      for (int p = 0; p < 3; p++) begin cycle(1, 0); chk_level("R2"); end
      for (int r = 0; r < 5; r++) cycle(0, 1);
      chk_level("R3");

      // R8 push and pop together
      cycle(1, 1);
      chk_level("R8");

      // drain, R10
      while (mcount > 0) cycle(0, 1);
      chk_level("R10");
      cycle(0, 1);
      chk_level("R7");

      // R9 fill exactly to capacity
      for (int p = 0; p < DEPTH / 4; p++) cycle(1, 0);
      chk_level("R9");
      chk("R9 full level", 32'(occupancy), DEPTH);
      chk("R6 no drop yet", 32'(drop_seen), 0);

      // R5 R6 drop at full
      cycle(1, 0);
      chk_level("R5");
      chk("R6 drop_seen set", 32'(drop_seen), 1);

      // R9 boundary: 2047 drops, 2044 accepts
      cycle(0, 1);
      cycle(1, 0);
      chk_level("R9 at 2047");
      for (int r = 0; r < 3; r++) cycle(0, 1);
      cycle(1, 0);
      chk_level("R9 at 2044");
      chk("R9 refilled", 32'(occupancy), DEPTH);

      // drain everything, R3 ordering, R6 still set
      while (mcount > 0) cycle(0, 1);
      chk_level("R3 drained");
      chk("R6 sticky", 32'(drop_seen), 1);
      cycle(0, 1);
      @(negedge clk);

      // R1 reset clears the flag and level
      cycle(1, 0);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      model.delete();
      mcount = 0;
      @(negedge clk);
      chk("R1 drop cleared", 32'(drop_seen), 0);
      chk_level("R1");

      summary();
      $finish;
   end
endmodule